// File: doc/BRIEF.md
# Bus Window Address Translator

This block sits between a local memory-mapped port and the bus-cycle engine of a host bridge. A 1 GB local window, at local addresses 0x8000_0000 up to 0xBFFF_FFFF, is turned into outbound bus cycles. Addresses outside the window are answered locally with an error and never reach the bus. A control register selects whether the window produces memory cycles or configuration cycles. In memory mode the two top bus address bits come from a programmable field. In configuration mode the low part of the window offset is decoded into a one-hot device select, a function number and a dword register index.

Configuration cycles are always whole dwords on the bus. A configuration write that enables fewer than four byte lanes is done as a read of the dword, a merge of the enabled lanes, and a write of the merged dword. Offsets that cannot name exactly one device inside the 1 MB configuration region are refused without any bus traffic. A refused or aborted configuration access reads back as all ones and raises a one-cycle abort pulse. Control register writes are held back until no request is in flight, so a request always completes in the mode in which it was accepted.

Top module: `bus_window_xlate`

## Requirements
- R1: A request whose address bits 31:30 are not 2'b10 creates no bus cycle and gets an error response with read data 0xFFFF_FFFF and no abort pulse.
- R2: In memory mode, bus address bits 29:0 equal request address bits 29:0 and bus address bits 31:30 equal control bits 3:2; bus_cfg is 0.
- R3: Control bit 1 selects the cycle type (0 memory, 1 configuration); ctl_rdata shows the active control value in bits 3:1 with all other bits zero.
- R4: In configuration mode the bus address is the offset bits 19:2 with bits 1:0 and 31:20 zero; bus_cfg_dev is the index of the set bit among offset bits 19:13 (device n at bit 13+n), bus_cfg_func is offset bits 10:8 and bus_cfg_reg is offset bits 7:2.
- R5: A configuration request is refused, with no bus cycle, an error response, read data 0xFFFF_FFFF and an abort pulse, when offset bits 29:20 are not all zero, when offset bits 19:13 do not have exactly one bit set, or when the device number exceeds MAX_DEV.
- R6: Every configuration bus cycle has all byte enables set; a configuration read returns the full bus dword, and a configuration write with all four enables set is one bus write of the request data.
- R7: A configuration write with fewer than four enables issues a bus read of the dword, then a bus write whose enabled lanes come from the request and whose other lanes come from the read data.
- R8: A bus abort ends the request with an error response and a one-cycle abort pulse; configuration reads then return 0xFFFF_FFFF, memory reads return the bus data, and an abort on the first half of a merged write stops the write half.
- R9: Memory cycles carry the request byte enables and write data unchanged, and memory reads return the bus read data.
- R10: A control write takes effect only in a cycle with no request in flight; while it is waiting, req_ready is low and ctl_rdata keeps the old value.
- R11: After reset the control value is memory mode with the upper-bits field at zero, req_ready is high, and rsp_valid, abort_pulse and bus_req_valid are low.
- R12: Each accepted request gets exactly one rsp_valid pulse of one cycle, and abort_pulse is only high together with rsp_valid and rsp_err.
- R13: bus_req_valid, bus_addr and bus_write stay unchanged until bus_req_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | DW (32) | Control write value (bit 1 mode, bits 3:2 upper address bits) |
| ctl_rdata | output | DW (32) | Active control value |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Local request accepted when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW (32) | Local byte address |
| req_wdata | input | DW (32) | Local write data |
| req_be | input | BE_W (4) | Local byte enables |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW (32) | Response read data |
| rsp_err | output | 1 | Response carries an error |
| abort_pulse | output | 1 | One-cycle abort status |
| bus_req_valid | output | 1 | Bus cycle request |
| bus_req_ready | input | 1 | Bus engine takes the cycle |
| bus_cfg | output | 1 | 1 configuration cycle, 0 memory cycle |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | AW (32) | Bus address |
| bus_be | output | BE_W (4) | Bus byte enables |
| bus_wdata | output | DW (32) | Bus write data |
| bus_cfg_dev | output | DEV_W (3) | Decoded device number |
| bus_cfg_func | output | FUNC_W (3) | Decoded function number |
| bus_cfg_reg | output | REG_W (6) | Decoded dword register index |
| bus_rsp_valid | input | 1 | Bus cycle completion |
| bus_rdata | input | DW (32) | Bus read data |
| bus_abort | input | 1 | Bus cycle ended in abort |

## Verification
The bench aims at the offsets that sit on the edge of the configuration decode: the first offset past 1 MB, an offset with no device bit and one with two device bits; a design that only masked the address would send such cycles to the bus or select two devices. It drives sub-dword configuration writes, where a design without the merge would clobber the untouched lanes, and an abort on the read half of such a write, where a careless sequencer would still issue the write. A control write is placed while a memory request is in flight, which exposes a design that switches the mode mid-request or lets a new request in before the change lands, and the bus engine stalls its ready so that a design that drops or alters a waiting cycle is caught.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } bwx_state_e;

endpackage

// File: rtl/bwx_ctl_reg.sv
module bwx_ctl_reg #(
   parameter int DW      = 32,
   parameter int WIN_W   = 2,
   parameter int CFG_BIT = 1,
   parameter int HI_LO   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [DW-1:0]    wdata,
   input  logic             idle,
   output logic             cfg_mode,
   output logic [WIN_W-1:0] hi_bits,
   output logic             pend
);

   if (CFG_BIT >= DW || HI_LO + WIN_W > DW) begin : g_bad_fields
      $error("control fields do not fit in DW");
   end
   if (CFG_BIT >= HI_LO && CFG_BIT < HI_LO + WIN_W) begin : g_overlap
      $error("mode bit overlaps upper-bits field");
   end

   logic             pend_cfg;
   logic [WIN_W-1:0] pend_hi;
   wire              unused_ctl_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode <= 1'b0;
         hi_bits  <= '0;
         pend     <= 1'b0;
         pend_cfg <= 1'b0;
         pend_hi  <= '0;
      end else begin
         if (pend && idle) begin
            cfg_mode <= pend_cfg;
            hi_bits  <= pend_hi;
         end
         if (we) begin
            pend     <= 1'b1;
            pend_cfg <= wdata[CFG_BIT];
            pend_hi  <= wdata[HI_LO +: WIN_W];
         end else if (pend && idle) begin
            pend <= 1'b0;
         end
      end
   end

   // R10: active control value is frozen while a request is in flight
   a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(cfg_mode) && $stable(hi_bits)));

endmodule

// File: rtl/bwx_decode.sv
module bwx_decode #(
   parameter int               AW      = 32,
   parameter int               WIN_W   = 2,
   parameter logic [WIN_W-1:0] WIN_TAG = 2'b10,
   parameter int               CFG_AW  = 20,
   parameter int               DEV_LO  = 13,
   parameter int               FUNC_LO = 8,
   parameter int               FUNC_W  = 3,
   parameter int               REG_LO  = 2,
   parameter int               REG_W   = 6,
   parameter int               MAX_DEV = 18,
   parameter int               DEV_W   = 3
) (
   input  logic [AW-1:0]     addr,
   input  logic [WIN_W-1:0]  hi_bits,
   output logic              in_win,
   output logic              cfg_ok,
   output logic [AW-1:0]     mem_addr,
   output logic [AW-1:0]     cfg_addr,
   output logic [DEV_W-1:0]  dev,
   output logic [FUNC_W-1:0] func,
   output logic [REG_W-1:0]  regidx
);

   localparam int OFF_W = AW - WIN_W;
   localparam int NSEL  = CFG_AW - DEV_LO;

   if (NSEL < 2 || DEV_W < $clog2(NSEL)) begin : g_bad_sel
      $error("device select field too narrow");
   end
   if (CFG_AW >= OFF_W) begin : g_bad_region
      $error("configuration region must be smaller than the window");
   end

   logic [NSEL-1:0] sel;
   logic            region_ok;
   logic            one_dev;
   logic            dev_ok;

   assign in_win    = (addr[AW-1 -: WIN_W] == WIN_TAG);
   assign mem_addr  = {hi_bits, addr[OFF_W-1:0]};
   assign cfg_addr  = {{(AW-CFG_AW){1'b0}}, addr[CFG_AW-1:REG_LO], {REG_LO{1'b0}}};
   assign sel       = addr[CFG_AW-1:DEV_LO];
   assign region_ok = (addr[OFF_W-1:CFG_AW] == '0);
   assign one_dev   = ($countones(sel) == 1);
   assign func      = addr[FUNC_LO +: FUNC_W];
   assign regidx    = addr[REG_LO +: REG_W];

   always_comb begin
      dev = '0;
      for (int i = 0; i < NSEL; i++) begin
         if (sel[i]) dev = dev | DEV_W'(i);
      end
   end

   if (MAX_DEV >= NSEL - 1) begin : g_dev_any
      assign dev_ok = 1'b1;
   end else begin : g_dev_cap
      localparam logic [DEV_W-1:0] MAX_DEV_V = DEV_W'(MAX_DEV);
      assign dev_ok = (dev <= MAX_DEV_V);
   end

   assign cfg_ok = region_ok && one_dev && dev_ok;

endmodule

// File: rtl/bwx_merge.sv
module bwx_merge #(
   parameter int DW   = 32,
   parameter int BE_W = DW / 8
) (
   input  logic [DW-1:0]   old_data,
   input  logic [DW-1:0]   new_data,
   input  logic [BE_W-1:0] lanes,
   output logic [DW-1:0]   merged
);

   if (BE_W * 8 != DW) begin : g_bad_lanes
      $error("DW must be a whole number of bytes");
   end

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign merged[b*8 +: 8] = lanes[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
   end

endmodule

// File: rtl/bwx_seq.sv
module bwx_seq
   import bwx_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int BE_W    = DW / 8,
   parameter int DEV_W   = 3,
   parameter int FUNC_W  = 3,
   parameter int REG_W   = 6,
   parameter int DEV_LO  = 13,
   parameter int CFG_AW  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend,
   input  logic              cfg_mode,
   output logic              idle,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DW-1:0]     req_wdata,
   input  logic [BE_W-1:0]   req_be,
   input  logic              in_win,
   input  logic              cfg_ok,
   input  logic [AW-1:0]     mem_addr,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FUNC_W-1:0] func,
   input  logic [REG_W-1:0]  regidx,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic              rsp_err,
   output logic              abort_pulse,
   output logic              bus_req_valid,
   input  logic              bus_req_ready,
   output logic              bus_cfg,
   output logic              bus_write,
   output logic [AW-1:0]     bus_addr,
   output logic [BE_W-1:0]   bus_be,
   output logic [DW-1:0]     bus_wdata,
   output logic [DEV_W-1:0]  bus_cfg_dev,
   output logic [FUNC_W-1:0] bus_cfg_func,
   output logic [REG_W-1:0]  bus_cfg_reg,
   input  logic              bus_rsp_valid,
   input  logic [DW-1:0]     bus_rdata,
   input  logic              bus_abort
);

   bwx_state_e      st;
   logic            rmw_q;
   logic [BE_W-1:0] lanes_q;
   logic [DW-1:0]   data_q;
   logic            err_q;
   logic            abort_q;
   logic [DW-1:0]   merged;
   logic            accept;
   logic            partial;

   assign idle          = (st == ST_IDLE);
   assign req_ready     = idle && !pend;
   assign accept        = req_valid && req_ready;
   assign partial       = req_write && (req_be != '1);
   assign bus_req_valid = (st == ST_ISSUE);
   assign rsp_valid     = (st == ST_RESP);
   assign rsp_rdata     = data_q;
   assign rsp_err       = err_q;
   assign abort_pulse   = rsp_valid && abort_q;

   bwx_merge #(.DW(DW), .BE_W(BE_W)) u_merge (
      .old_data (bus_rdata),
      .new_data (bus_wdata),
      .lanes    (lanes_q),
      .merged   (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         rmw_q        <= 1'b0;
         lanes_q      <= '0;
         data_q       <= '0;
         err_q        <= 1'b0;
         abort_q      <= 1'b0;
         bus_cfg      <= 1'b0;
         bus_write    <= 1'b0;
         bus_addr     <= '0;
         bus_be       <= '0;
         bus_wdata    <= '0;
         bus_cfg_dev  <= '0;
         bus_cfg_func <= '0;
         bus_cfg_reg  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  if (!in_win) begin
                     err_q   <= 1'b1;
                     abort_q <= 1'b0;
                     data_q  <= '1;
                     st      <= ST_RESP;
                  end else if (cfg_mode && !cfg_ok) begin
                     err_q   <= 1'b1;
                     abort_q <= 1'b1;
                     data_q  <= '1;
                     st      <= ST_RESP;
                  end else begin
                     bus_cfg      <= cfg_mode;
                     bus_addr     <= cfg_mode ? cfg_addr : mem_addr;
                     bus_be       <= cfg_mode ? '1 : req_be;
                     bus_wdata    <= req_wdata;
                     bus_cfg_dev  <= dev;
                     bus_cfg_func <= func;
                     bus_cfg_reg  <= regidx;
                     lanes_q      <= req_be;
                     rmw_q        <= cfg_mode && partial;
                     bus_write    <= req_write && !(cfg_mode && partial);
                     st           <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (bus_req_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (bus_rsp_valid) begin
                  if (bus_abort) begin
                     err_q   <= 1'b1;
                     abort_q <= 1'b1;
                     data_q  <= bus_cfg ? '1 : bus_rdata;
                     rmw_q   <= 1'b0;
                     st      <= ST_RESP;
                  end else if (rmw_q) begin
                     bus_wdata <= merged;
                     bus_write <= 1'b1;
                     rmw_q     <= 1'b0;
                     st        <= ST_ISSUE;
                  end else begin
                     err_q   <= 1'b0;
                     abort_q <= 1'b0;
                     data_q  <= bus_rdata;
                     st      <= ST_RESP;
                  end
               end
            end
            ST_RESP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R13: a waiting bus cycle is held unchanged
   a_r13_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_req_ready) |=>
         (bus_req_valid && $stable(bus_addr) && $stable(bus_write)));

   // R6: configuration cycles are whole dwords
   a_r6_cfg_full_be: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_cfg) |-> (bus_be == '1));

   // R4: configuration address names one device, aligned, inside the region
   a_r4_cfg_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_cfg) |->
         (($countones(bus_addr[CFG_AW-1:DEV_LO]) == 1) && (bus_addr[1:0] == 2'b00)
          && (bus_addr[AW-1:CFG_AW] == '0)));

   // R12: response strobe lasts one cycle
   a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R12: abort status only with an error response
   a_r12_abort_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (rsp_valid && rsp_err));

   // R10: no request is taken while a control write waits
   a_r10_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !req_ready);

endmodule

// File: rtl/bus_window_xlate.sv
module bus_window_xlate #(
   parameter int               AW      = 32,
   parameter int               DW      = 32,
   parameter int               BE_W    = DW / 8,
   parameter int               WIN_W   = 2,
   parameter logic [WIN_W-1:0] WIN_TAG = 2'b10,
   parameter int               CFG_AW  = 20,
   parameter int               DEV_LO  = 13,
   parameter int               FUNC_LO = 8,
   parameter int               FUNC_W  = 3,
   parameter int               REG_LO  = 2,
   parameter int               REG_W   = 6,
   parameter int               MAX_DEV = 18,
   parameter int               DEV_W   = $clog2(CFG_AW - DEV_LO),
   parameter int               CFG_BIT = 1,
   parameter int               HI_LO   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [DW-1:0]     ctl_wdata,
   output logic [DW-1:0]     ctl_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic              rsp_err,
   output logic              abort_pulse,
   output logic              bus_req_valid,
   input  logic              bus_req_ready,
   output logic              bus_cfg,
   output logic              bus_write,
   output logic [AW-1:0]     bus_addr,
   output logic [BE_W-1:0]   bus_be,
   output logic [DW-1:0]     bus_wdata,
   output logic [DEV_W-1:0]  bus_cfg_dev,
   output logic [FUNC_W-1:0] bus_cfg_func,
   output logic [REG_W-1:0]  bus_cfg_reg,
   input  logic              bus_rsp_valid,
   input  logic [DW-1:0]     bus_rdata,
   input  logic              bus_abort
);

   if (REG_LO != 2 || REG_LO + REG_W > FUNC_LO || FUNC_LO + FUNC_W > DEV_LO
       || DEV_LO >= CFG_AW) begin : g_bad_cfg_layout
      $error("configuration offset fields overlap or are misordered");
   end
   if (BE_W * 8 != DW || DW != 32) begin : g_bad_data
      $error("data path must be one 32-bit dword");
   end

   logic              cfg_mode;
   logic [WIN_W-1:0]  hi_bits;
   logic              pend;
   logic              idle;
   logic              in_win;
   logic              cfg_ok;
   logic [AW-1:0]     mem_addr;
   logic [AW-1:0]     cfg_addr;
   logic [DEV_W-1:0]  dev;
   logic [FUNC_W-1:0] func;
   logic [REG_W-1:0]  regidx;

   bwx_ctl_reg #(
      .DW(DW), .WIN_W(WIN_W), .CFG_BIT(CFG_BIT), .HI_LO(HI_LO)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl_we),
      .wdata    (ctl_wdata),
      .idle     (idle),
      .cfg_mode (cfg_mode),
      .hi_bits  (hi_bits),
      .pend     (pend)
   );

   always_comb begin
      ctl_rdata                   = '0;
      ctl_rdata[CFG_BIT]          = cfg_mode;
      ctl_rdata[HI_LO +: WIN_W]   = hi_bits;
   end

   bwx_decode #(
      .AW(AW), .WIN_W(WIN_W), .WIN_TAG(WIN_TAG), .CFG_AW(CFG_AW),
      .DEV_LO(DEV_LO), .FUNC_LO(FUNC_LO), .FUNC_W(FUNC_W),
      .REG_LO(REG_LO), .REG_W(REG_W), .MAX_DEV(MAX_DEV), .DEV_W(DEV_W)
   ) u_dec (
      .addr     (req_addr),
      .hi_bits  (hi_bits),
      .in_win   (in_win),
      .cfg_ok   (cfg_ok),
      .mem_addr (mem_addr),
      .cfg_addr (cfg_addr),
      .dev      (dev),
      .func     (func),
      .regidx   (regidx)
   );

   bwx_seq #(
      .AW(AW), .DW(DW), .BE_W(BE_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
      .REG_W(REG_W), .DEV_LO(DEV_LO), .CFG_AW(CFG_AW)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .pend          (pend),
      .cfg_mode      (cfg_mode),
      .idle          (idle),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_write     (req_write),
      .req_wdata     (req_wdata),
      .req_be        (req_be),
      .in_win        (in_win),
      .cfg_ok        (cfg_ok),
      .mem_addr      (mem_addr),
      .cfg_addr      (cfg_addr),
      .dev           (dev),
      .func          (func),
      .regidx        (regidx),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .rsp_err       (rsp_err),
      .abort_pulse   (abort_pulse),
      .bus_req_valid (bus_req_valid),
      .bus_req_ready (bus_req_ready),
      .bus_cfg       (bus_cfg),
      .bus_write     (bus_write),
      .bus_addr      (bus_addr),
      .bus_be        (bus_be),
      .bus_wdata     (bus_wdata),
      .bus_cfg_dev   (bus_cfg_dev),
      .bus_cfg_func  (bus_cfg_func),
      .bus_cfg_reg   (bus_cfg_reg),
      .bus_rsp_valid (bus_rsp_valid),
      .bus_rdata     (bus_rdata),
      .bus_abort     (bus_abort)
   );

   // R1: a request outside the window never becomes a bus cycle
   a_r1_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !in_win) |=> rsp_valid && rsp_err && !bus_req_valid);

endmodule

// File: tb/bus_window_xlate_bench.sv
`timescale 1ns/1ps
module bus_window_xlate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic        abort_pulse;
   logic        bus_req_valid;
   logic        bus_req_ready = 1'b1;
   logic        bus_cfg;
   logic        bus_write;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;
   logic [2:0]  bus_cfg_dev;
   logic [2:0]  bus_cfg_func;
   logic [5:0]  bus_cfg_reg;
   logic        bus_rsp_valid = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        bus_abort = 1'b0;

   always #5 clk = ~clk;

   bus_window_xlate u_bus_window_xlate (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .abort_pulse(abort_pulse), .bus_req_valid(bus_req_valid),
      .bus_req_ready(bus_req_ready), .bus_cfg(bus_cfg), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_cfg_dev(bus_cfg_dev), .bus_cfg_func(bus_cfg_func),
      .bus_cfg_reg(bus_cfg_reg), .bus_rsp_valid(bus_rsp_valid),
      .bus_rdata(bus_rdata), .bus_abort(bus_abort)
   );

   typedef struct {
      logic        err;
      logic        ab;
      logic        chk;
      logic [31:0] data;
      string       tag;
   } rsp_t;

   typedef struct {
      logic [31:0] addr;
      logic        wr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        cfg;
      logic [2:0]  dev;
      logic [2:0]  func;
      logic [5:0]  regi;
      string       tag;
   } bus_t;

   rsp_t rsp_q[$];
   bus_t bus_q[$];
   logic [31:0] mem [logic [31:0]];
   int checks = 0;
   int fails = 0;
   logic       sh_cfg = 1'b0;
   logic [1:0] sh_hi = 2'b00;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mdl_read(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_0000);
   endfunction

   function automatic bit mdl_abort(input logic cfg, input logic [31:0] a);
      return cfg ? a[15] : (a[27:0] == 28'h0BAD000);
   endfunction

   function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
      return r;
   endfunction

   // bus engine model: stalls ready every third cycle, answers one cycle after acceptance
   int   stall_cnt = 0;
   bit   resp_due = 0;
   bus_t cur;
   always @(negedge clk) begin
      bus_rsp_valid = 1'b0;
      bus_abort     = 1'b0;
      if (rst_n) begin
         stall_cnt++;
         bus_req_ready = (stall_cnt % 3) != 0;
         if (resp_due) begin
            resp_due      = 0;
            bus_rsp_valid = 1'b1;
            bus_abort     = mdl_abort(cur.cfg, cur.addr);
            if (bus_abort) bus_rdata = 32'h0BAD_BAD0;
            else begin
               bus_rdata = mdl_read(cur.addr);
               if (cur.wr) mem[cur.addr] = bmerge(mdl_read(cur.addr), cur.wdata, cur.be);
            end
         end
         if (bus_req_valid && bus_req_ready) begin
            cur.addr = bus_addr; cur.wr = bus_write; cur.be = bus_be;
            cur.wdata = bus_wdata; cur.cfg = bus_cfg;
            resp_due = 1;
            if (bus_q.size() == 0) begin
               check(1'b0, "R1 R5 unexpected bus cycle", bus_addr, 32'h0);
            end else begin
               bus_t e;
               e = bus_q.pop_front();
               check(bus_addr == e.addr, {e.tag, " bus addr"}, bus_addr, e.addr);
               check(bus_write == e.wr, {e.tag, " bus write"}, 32'(bus_write), 32'(e.wr));
               check(bus_be == e.be, {e.tag, " bus be"}, 32'(bus_be), 32'(e.be));
               check(bus_cfg == e.cfg, {e.tag, " bus cfg"}, 32'(bus_cfg), 32'(e.cfg));
               if (e.wr)
                  check(bus_wdata == e.wdata, {e.tag, " bus wdata"}, bus_wdata, e.wdata);
               if (e.cfg) begin
                  check(bus_cfg_dev == e.dev, {e.tag, " R4 dev"}, 32'(bus_cfg_dev), 32'(e.dev));
                  check(bus_cfg_func == e.func, {e.tag, " R4 func"}, 32'(bus_cfg_func), 32'(e.func));
                  check(bus_cfg_reg == e.regi, {e.tag, " R4 reg"}, 32'(bus_cfg_reg), 32'(e.regi));
               end
            end
         end
      end
   end

   // response monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (rsp_q.size() == 0) begin
            check(1'b0, "R12 unexpected response", rsp_rdata, 32'h0);
         end else begin
            rsp_t e;
            e = rsp_q.pop_front();
            check(rsp_err == e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
            check(abort_pulse == e.ab, {e.tag, " abort"}, 32'(abort_pulse), 32'(e.ab));
            if (e.chk) check(rsp_rdata == e.data, {e.tag, " rdata"}, rsp_rdata, e.data);
         end
      end else if (rst_n && abort_pulse) begin
         check(1'b0, "R12 abort without response", 32'h1, 32'h0);
      end
   end

   task automatic push_rsp(input logic err, input logic ab, input logic chk,
                           input logic [31:0] d, input string tag);
      rsp_t r;
      r.err = err; r.ab = ab; r.chk = chk; r.data = d; r.tag = tag;
      rsp_q.push_back(r);
   endtask

   task automatic push_bus(input logic [31:0] a, input logic wr, input logic [3:0] be,
                           input logic [31:0] d, input logic cfg, input string tag);
      bus_t b;
      b.addr = a; b.wr = wr; b.be = be; b.wdata = d; b.cfg = cfg; b.tag = tag;
      b.dev = '0;
      for (int i = 0; i < 7; i++) if (a[13+i]) b.dev = 3'(i);
      b.func = a[10:8]; b.regi = a[7:2];
      bus_q.push_back(b);
   endtask

   task automatic drive(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (rsp_q.size() != 0 || bus_q.size() != 0) @(negedge clk);
   endtask

   // expected results for one local access under the bench's view of the control value
   task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input string tag);
      if (a[31:30] != 2'b10) begin
         push_rsp(1'b1, 1'b0, !wr, 32'hFFFF_FFFF, tag);
      end else if (!sh_cfg) begin
         logic [31:0] ba;
         bit ab;
         ba = {sh_hi, a[29:0]};
         ab = mdl_abort(1'b0, ba);
         push_bus(ba, wr, be, d, 1'b0, tag);
         push_rsp(ab, ab, !wr, ab ? 32'h0BAD_BAD0 : mdl_read(ba), tag);
      end else if (a[29:20] != 0 || $countones(a[19:13]) != 1) begin
         push_rsp(1'b1, 1'b1, !wr, 32'hFFFF_FFFF, tag);
      end else begin
         logic [31:0] ba;
         bit ab;
         ba = {12'h000, a[19:2], 2'b00};
         ab = mdl_abort(1'b1, ba);
         if (!wr) begin
            push_bus(ba, 1'b0, 4'hF, 32'h0, 1'b1, tag);
            push_rsp(ab, ab, 1'b1, ab ? 32'hFFFF_FFFF : mdl_read(ba), tag);
         end else if (be == 4'hF) begin
            push_bus(ba, 1'b1, 4'hF, d, 1'b1, tag);
            push_rsp(ab, ab, 1'b0, 32'h0, tag);
         end else begin
            push_bus(ba, 1'b0, 4'hF, 32'h0, 1'b1, tag);
            if (!ab) push_bus(ba, 1'b1, 4'hF, bmerge(mdl_read(ba), d, be), 1'b1, tag);
            push_rsp(ab, ab, 1'b0, 32'h0, tag);
         end
      end
      drive(wr, a, d, be);
   endtask

   task automatic ctl_write(input logic [31:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      sh_cfg = v[1]; sh_hi = v[3:2];
      check(ctl_rdata == {28'h0, v[3:1], 1'b0}, "R3 control readback", ctl_rdata,
            {28'h0, v[3:1], 1'b0});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(ctl_rdata == 32'h0, "R11 control reset", ctl_rdata, 32'h0);
      check(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'h1);
      check(rsp_valid == 1'b0 && abort_pulse == 1'b0, "R11 no response", 32'(rsp_valid), 32'h0);
      check(bus_req_valid == 1'b0, "R11 no bus cycle", 32'(bus_req_valid), 32'h0);

      // R2 R9 memory mode, upper bits zero, then two
      access(1'b0, 32'h8000_1234, 32'h0, 4'hF, "R2 R9 mem read");
      ctl_write(32'h0000_0008);
      access(1'b1, 32'h8000_0040, 32'h1122_3344, 4'b0101, "R9 mem write be");
      access(1'b0, 32'h8000_0040, 32'h0, 4'hF, "R9 mem readback");
      access(1'b0, 32'hBFFF_FFFC, 32'h0, 4'b1000, "R2 mem top of window");

      // R1 outside the window
      access(1'b0, 32'h4000_0000, 32'h0, 4'hF, "R1 below window");
      access(1'b1, 32'hC000_0010, 32'h5555_5555, 4'hF, "R1 above window");

      // R8 memory abort passes bus data
      access(1'b0, 32'h80BA_D000, 32'h0, 4'hF, "R8 mem abort");

      // configuration mode
      ctl_write(32'h0000_000A);
      access(1'b0, 32'h8000_2111, 32'h0, 4'b0010, "R4 R6 cfg read dev0");
      access(1'b1, 32'h8001_0008, 32'hCAFE_F00D, 4'hF, "R6 cfg full write dev3");
      access(1'b0, 32'h8001_0008, 32'h0, 4'hF, "R6 cfg readback dev3");
      access(1'b1, 32'h8000_2110, 32'h0000_AB00, 4'b0010, "R7 cfg partial write");
      access(1'b0, 32'h8000_2110, 32'h0, 4'hF, "R7 cfg readback merged");
      access(1'b1, 32'h8008_07FC, 32'h1357_9BDF, 4'b1100, "R7 R4 cfg dev6 partial");

      // R5 refusals
      access(1'b0, 32'h8010_0000, 32'h0, 4'hF, "R5 offset at 1MB");
      access(1'b0, 32'h8000_0100, 32'h0, 4'hF, "R5 no device bit");
      access(1'b1, 32'h8000_6000, 32'h1, 4'hF, "R5 two device bits");
      access(1'b0, 32'h8400_2000, 32'h0, 4'hF, "R5 high offset bits");

      // R8 configuration aborts
      access(1'b0, 32'h8000_8000, 32'h0, 4'hF, "R8 cfg read abort");
      access(1'b1, 32'h8000_8004, 32'h0000_00EE, 4'b0001, "R8 cfg merge abort");

      // R10 control write while a request is in flight
      begin
         logic [31:0] old_v;
         old_v = ctl_rdata;
         push_bus(32'h0001_0008, 1'b0, 4'hF, 32'h0, 1'b1, "R10 inflight cfg");
         push_rsp(1'b0, 1'b0, 1'b1, mdl_read(32'h0001_0008), "R10 inflight cfg");
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h8001_0008; req_be = 4'hF;
         while (!req_ready) @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         ctl_we = 1'b1; ctl_wdata = 32'h0000_0004;
         @(negedge clk);
         ctl_we = 1'b0;
         check(ctl_rdata == old_v, "R10 old value while busy", ctl_rdata, old_v);
         while (!rsp_valid) @(negedge clk);
         @(negedge clk);
         check(req_ready == 1'b0, "R10 ready low while pending", 32'(req_ready), 32'h0);
         check(ctl_rdata == old_v, "R10 not yet applied", ctl_rdata, old_v);
         @(negedge clk);
         check(ctl_rdata == 32'h0000_0004, "R10 applied when idle", ctl_rdata, 32'h4);
         check(req_ready == 1'b1, "R10 ready after apply", 32'(req_ready), 32'h1);
         sh_cfg = 1'b0; sh_hi = 2'b01;
         while (rsp_q.size() != 0 || bus_q.size() != 0) @(negedge clk);
      end
      access(1'b0, 32'h8000_0080, 32'h0, 4'hF, "R2 mem after mode change");

      repeat (4) @(negedge clk);
      check(rsp_q.size() == 0 && bus_q.size() == 0, "R12 all responses seen",
            32'(rsp_q.size() + bus_q.size()), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule